// File: doc/BRIEF.md
# Four-State Branching Trigger Sequencer

This block decides when a bus logic analyzer triggers and which samples it stores. Every clock it takes four Boolean pattern-match terms, which are computed elsewhere, together with the zero status of a 32-bit event counter. It looks up the programmed branches of its current state and takes at most one of them. A branch moves the sequencer to a new state. It can also turn the trigger enable and the store enable on or off, and it can reload the counter or count it down by one.

A branch condition is a 32-entry truth table indexed by the four terms and the counter-zero bit, so any AND/OR/XOR/negation expression can be expressed. Loading the counter with N and then counting it down on each matching event makes it possible to act only on every Nth event. Branches are written through a small register port.

After that, software pulses `run_i`. The sequencer then starts in state 0, and the trigger output stays latched until the next run or reset.

Top module: `trig_seq_top`

## Requirements
- R1: After reset the outputs are as follows: `state_o`=0, `trig_o`=0, `store_o`=0 and `cnt_zero_o`=1. The sequencer takes no branch until `run_i` has been seen, whatever `terms_i` is.
- R2: A cycle with `run_i`=1 forces the following on the next edge: state 0, trigger enable and `trig_o` cleared, store enable cleared, counter cleared to 0. Branch evaluation starts on the following edge. If a branch would also fire in the `run_i` cycle, `run_i` takes precedence.
- R3: The register port writes on `cfg_we_i`. The field `cfg_addr_i[7:6]` selects the target: 0 is the truth table of a slot, 1 is the control word of a slot, 2 is the counter preload value. The field `cfg_addr_i[5:0]` is the slot, equal to state*16 + index.
- R4: A slot's condition is bit `{cnt_zero, terms_i[3:0]}` of its 32-bit truth table.
- R5: Only the 16 slots of the current state are considered. When several are true, the lowest index wins.
- R6: If no slot of the current state fires, the state, the counter, the trigger enable, the store enable and `trig_o` all hold.
- R7: Control bits [4:3] set the trigger action: 0 keep, 1 enable, 2 disable. `trig_o` goes high on the edge where the trigger enable becomes 1. It stays high until run or reset, even if the enable is later disabled.
- R8: Control bits [6:5] set the store action, with the same encoding as R7. `store_o` shows the store enable one edge after the taken branch.
- R9: Control bits [8:7] set the counter action: 0 none, 1 load the preload value, 2 decrement. A decrement at zero stays at zero. `cnt_zero_o` is 1 exactly when the counter is 0.
- R10: Control bit [0] enables the slot, and a disabled slot never fires. Control bits [2:1] give the next state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register port write strobe |
| cfg_addr_i | input | 8 | Register port address: target select and slot |
| cfg_wdata_i | input | 32 | Register port write data |
| run_i | input | 1 | Start or restart the sequencer in state 0 |
| terms_i | input | 4 | Pattern-match terms for the current sample |
| state_o | output | 2 | Current sequencer state |
| trig_o | output | 1 | Latched trigger |
| store_o | output | 1 | Store qualifier for the current sample |
| cnt_zero_o | output | 1 | Termination counter equals zero |

## Verification
The taken branch is decided combinationally from the terms and the current state, and every result is registered on that same edge. State, `trig_o`, `store_o` and `cnt_zero_o` therefore change exactly one clock after the terms are presented. A run pulse acts with the same one-clock delay.

The bench drives each input on a falling edge and compares all four outputs on the next falling edge. It walks a vector table through priority, hold, every-Nth counting, saturation and sticky-trigger cases. Directed cases then cover reset, the idle state before run, and run winning over a firing branch.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;
  localparam int STATE_W = 2;

  typedef enum logic [1:0] {
    ACT_KEEP = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2
  } flag_act_e;

  typedef enum logic [1:0] {
    CNT_NONE = 2'd0,
    CNT_LOAD = 2'd1,
    CNT_DEC  = 2'd2
  } cnt_act_e;

  // packed LSB first: en[0], next[2:1], trig[4:3], store[6:5], cnt[8:7]
  typedef struct packed {
    cnt_act_e           cnt_act;
    flag_act_e          store_act;
    flag_act_e          trig_act;
    logic [STATE_W-1:0] next_state;
    logic               en;
  } br_ctrl_t;

  localparam int CTRL_W = $bits(br_ctrl_t);

  function automatic logic apply_act(input flag_act_e act, input logic cur);
    case (act)
      ACT_SET: apply_act = 1'b1;
      ACT_CLR: apply_act = 1'b0;
      default: apply_act = cur;
    endcase
  endfunction
endpackage

// File: rtl/trig_branch_table.sv
module trig_branch_table
  import trig_seq_pkg::*;
#(
  parameter int N_STATES = 4,
  parameter int SLOTS    = 16,
  parameter int TT_W     = 32,
  parameter int DW       = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_tt_i,
  input  logic                        we_ctrl_i,
  input  logic [$clog2(N_STATES*SLOTS)-1:0] waddr_i,
  input  logic [DW-1:0]               wdata_i,
  input  logic [STATE_W-1:0]          rd_state_i,
  output logic [SLOTS-1:0][TT_W-1:0]  tt_o,
  output br_ctrl_t [SLOTS-1:0]        ctrl_o
);
  localparam int N_ENT  = N_STATES * SLOTS;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int IDX_W  = $clog2(N_ENT);

  logic [TT_W-1:0] tt_q   [N_ENT];
  br_ctrl_t        ctrl_q [N_ENT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_ENT; i++) begin
        tt_q[i]   <= '0;
        ctrl_q[i] <= '0;
      end
    end else begin
      if (we_tt_i)   tt_q[waddr_i]   <= wdata_i[TT_W-1:0];
      if (we_ctrl_i) ctrl_q[waddr_i] <= br_ctrl_t'(wdata_i[CTRL_W-1:0]);
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_rd
    logic [IDX_W-1:0] ra;
    assign ra        = {rd_state_i, SLOT_W'(s)};
    assign tt_o[s]   = tt_q[ra];
    assign ctrl_o[s] = ctrl_q[ra];
  end
endmodule

// File: rtl/trig_branch_pick.sv
module trig_branch_pick
  import trig_seq_pkg::*;
#(
  parameter int SLOTS = 16,
  parameter int TT_W  = 32
) (
  input  logic [SLOTS-1:0][TT_W-1:0] tt_i,
  input  br_ctrl_t [SLOTS-1:0]       ctrl_i,
  input  logic [$clog2(TT_W)-1:0]    idx_i,
  output logic                       hit_o,
  output br_ctrl_t                   sel_o
);
  logic [SLOTS-1:0] cond;

  for (genvar s = 0; s < SLOTS; s++) begin : g_cond
    assign cond[s] = ctrl_i[s].en & tt_i[s][idx_i];
  end

  // lowest index has priority
  always_comb begin
    hit_o = 1'b0;
    sel_o = '0;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (cond[s]) begin
        hit_o = 1'b1;
        sel_o = ctrl_i[s];
      end
    end
  end
endmodule

// File: rtl/trig_term_counter.sv
module trig_term_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic             dec_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  assign zero_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (load_i)            cnt_q <= load_val_i;
    else if (dec_i && !zero_o)  cnt_q <= cnt_q - 1'b1;
  end

  p_dec_sat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !load_i) |=> zero_o);
  p_dec_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !zero_o && !load_i && !clr_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dec_i && !load_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/trig_seq_top.sv
module trig_seq_top
  import trig_seq_pkg::*;
#(
  parameter int N_TERMS  = 4,
  parameter int CNT_W    = 32,
  parameter int SLOTS    = 16,
  parameter int N_STATES = 4,
  parameter int ADDR_W   = 8,
  parameter int DW       = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [ADDR_W-1:0]  cfg_addr_i,
  input  logic [DW-1:0]      cfg_wdata_i,
  input  logic               run_i,
  input  logic [N_TERMS-1:0] terms_i,
  output logic [STATE_W-1:0] state_o,
  output logic               trig_o,
  output logic               store_o,
  output logic               cnt_zero_o
);
  localparam int TI_W  = N_TERMS + 1;
  localparam int TT_W  = 2 ** TI_W;
  localparam int IDX_W = $clog2(N_STATES * SLOTS);
  localparam logic [1:0] SEL_TT = 2'd0, SEL_CTRL = 2'd1, SEL_LOAD = 2'd2;

  logic [1:0]       cfg_sel;
  logic [IDX_W-1:0] cfg_slot;
  logic [CNT_W-1:0] preload_q;
  assign cfg_sel  = cfg_addr_i[ADDR_W-1 -: 2];
  assign cfg_slot = cfg_addr_i[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) preload_q <= '0;
    else if (cfg_we_i && cfg_sel == SEL_LOAD) preload_q <= CNT_W'(cfg_wdata_i);
  end

  logic [STATE_W-1:0]                state_q;
  logic                              running_q, trig_en_q, store_en_q, trig_q;
  logic [SLOTS-1:0][TT_W-1:0]        tt_w;
  br_ctrl_t [SLOTS-1:0]              ctrl_w;
  br_ctrl_t                          sel;
  logic                              hit, fire, cnt_zero, trig_en_nx;

  trig_branch_table #(
    .N_STATES(N_STATES), .SLOTS(SLOTS), .TT_W(TT_W), .DW(DW)
  ) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_tt_i   (cfg_we_i && cfg_sel == SEL_TT),
    .we_ctrl_i (cfg_we_i && cfg_sel == SEL_CTRL),
    .waddr_i   (cfg_slot),
    .wdata_i   (cfg_wdata_i),
    .rd_state_i(state_q),
    .tt_o      (tt_w),
    .ctrl_o    (ctrl_w)
  );

  trig_branch_pick #(.SLOTS(SLOTS), .TT_W(TT_W)) u_pick (
    .tt_i  (tt_w),
    .ctrl_i(ctrl_w),
    .idx_i ({cnt_zero, terms_i}),
    .hit_o (hit),
    .sel_o (sel)
  );

  assign fire = running_q && hit && !run_i;

  trig_term_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (run_i),
    .load_i    (fire && sel.cnt_act == CNT_LOAD),
    .dec_i     (fire && sel.cnt_act == CNT_DEC),
    .load_val_i(preload_q),
    .zero_o    (cnt_zero)
  );

  assign trig_en_nx = apply_act(sel.trig_act, trig_en_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_q  <= 1'b0;
      state_q    <= '0;
      trig_en_q  <= 1'b0;
      store_en_q <= 1'b0;
      trig_q     <= 1'b0;
    end else if (run_i) begin
      running_q  <= 1'b1;
      state_q    <= '0;
      trig_en_q  <= 1'b0;
      store_en_q <= 1'b0;
      trig_q     <= 1'b0;
    end else if (fire) begin
      state_q    <= sel.next_state;
      trig_en_q  <= trig_en_nx;
      store_en_q <= apply_act(sel.store_act, store_en_q);
      trig_q     <= trig_q | trig_en_nx;
    end
  end

  assign state_o    = state_q;
  assign trig_o     = trig_q;
  assign store_o    = store_en_q;
  assign cnt_zero_o = cnt_zero;

  p_run_home_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> (state_o == '0 && !trig_o && !store_o && cnt_zero_o));
  p_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running_q && !run_i) |=> (state_o == '0 && !trig_o));
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !hit) |=> ($stable(state_o) && $stable(store_o) && $stable(trig_o)));
  p_trig_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_o && !run_i) |=> trig_o);
endmodule

// File: tb/tb_trig_seq_top.sv
module tb_trig_seq_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic       run = 1'b0;
  logic [3:0] terms = '0;
  logic [1:0] state;
  logic       trig, store, zero;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  trig_seq_top dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .run_i(run), .terms_i(terms),
    .state_o(state), .trig_o(trig), .store_o(store), .cnt_zero_o(zero)
  );

  // {terms, state, trig, store, zero}, each row one clock
  localparam logic [8:0] VEC [13] = '{
    {4'b0000, 2'd0, 1'b0, 1'b0, 1'b1},  // R6 R10 no hit, disabled slot ignored
    {4'b0010, 2'd2, 1'b0, 1'b0, 1'b1},  // R3 R4 slot1 of state 0
    {4'b0000, 2'd2, 1'b0, 1'b0, 1'b1},  // R6 hold
    {4'b0001, 2'd0, 1'b0, 1'b1, 1'b1},  // R8 slot15 store enable
    {4'b0011, 2'd1, 1'b0, 1'b1, 1'b0},  // R5 lowest wins, R9 preload
    {4'b0000, 2'd1, 1'b0, 1'b1, 1'b0},  // R6 counter held
    {4'b0100, 2'd1, 1'b0, 1'b1, 1'b0},  // R9 dec 3->2
    {4'b0100, 2'd1, 1'b0, 1'b1, 1'b0},  // R9 dec 2->1
    {4'b0100, 2'd1, 1'b0, 1'b1, 1'b1},  // R9 dec 1->0
    {4'b0000, 2'd3, 1'b1, 1'b0, 1'b1},  // R4 zero bit, R7 trigger
    {4'b1000, 2'd3, 1'b1, 1'b0, 1'b1},  // R9 saturate
    {4'b1111, 2'd0, 1'b1, 1'b1, 1'b1},  // R7 sticky after disable
    {4'b0000, 2'd0, 1'b1, 1'b1, 1'b1}   // R6 hold
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic [1:0] s, input logic t,
                         input logic st, input logic z);
    chk({req, " state"}, 32'(state), 32'(s));
    chk({req, " trig"},  32'(trig),  32'(t));
    chk({req, " store"}, 32'(store), 32'(st));
    chk({req, " zero"},  32'(zero),  32'(z));
  endtask

  task automatic cfg_wr(input logic [1:0] sel, input logic [5:0] slot, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = {sel, slot}; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // truth table: bit i true when (i & mask) == val, i = {zero, t3..t0}
  function automatic logic [31:0] tt(input logic [4:0] mask, input logic [4:0] val);
    logic [31:0] r = '0;
    for (int i = 0; i < 32; i++) r[i] = ((5'(i) & mask) == val);
    return r;
  endfunction

  // ctrl: en[0] next[2:1] trig[4:3] store[6:5] cnt[8:7]
  function automatic logic [31:0] ctl(input logic en, input logic [1:0] nx, input logic [1:0] ta,
                                      input logic [1:0] sa, input logic [1:0] ca);
    return {23'd0, ca, sa, ta, nx, en};
  endfunction

  task automatic step(input logic [3:0] t);
    terms = t;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk_all("R1 reset", 2'd0, 1'b0, 1'b0, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);

    cfg_wr(2'd2, 6'd0, 32'd3);
    cfg_wr(2'd0, 6'd0,  tt(5'b00001, 5'b00001));
    cfg_wr(2'd1, 6'd0,  ctl(1, 2'd1, 0, 1, 1));
    cfg_wr(2'd0, 6'd1,  tt(5'b00010, 5'b00010));
    cfg_wr(2'd1, 6'd1,  ctl(1, 2'd2, 0, 0, 0));
    cfg_wr(2'd0, 6'd2,  32'hffff_ffff);
    cfg_wr(2'd1, 6'd2,  ctl(0, 2'd3, 1, 1, 0));
    cfg_wr(2'd0, 6'd16, tt(5'b10100, 5'b00100));
    cfg_wr(2'd1, 6'd16, ctl(1, 2'd1, 0, 0, 2));
    cfg_wr(2'd0, 6'd17, tt(5'b10000, 5'b10000));
    cfg_wr(2'd1, 6'd17, ctl(1, 2'd3, 1, 2, 0));
    cfg_wr(2'd0, 6'd47, tt(5'b00001, 5'b00001));
    cfg_wr(2'd1, 6'd47, ctl(1, 2'd0, 0, 1, 0));
    cfg_wr(2'd0, 6'd48, tt(5'b01001, 5'b01000));
    cfg_wr(2'd1, 6'd48, ctl(1, 2'd3, 0, 0, 2));
    cfg_wr(2'd0, 6'd53, tt(5'b01111, 5'b01111));
    cfg_wr(2'd1, 6'd53, ctl(1, 2'd0, 2, 1, 0));

    step(4'b0010);
    chk_all("R1 idle before run", 2'd0, 1'b0, 1'b0, 1'b1);

    run = 1'b1; terms = 4'b0000;
    @(negedge clk);
    run = 1'b0;
    chk_all("R2 run", 2'd0, 1'b0, 1'b0, 1'b1);

    for (int i = 0; i < 13; i++) begin
      step(VEC[i][8:5]);
      chk_all($sformatf("row %0d R3 R4 R5 R6 R7 R8 R9 R10", i),
              VEC[i][4:3], VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    step(4'b0001);
    chk_all("R9 preload again", 2'd1, 1'b1, 1'b1, 1'b0);

    run = 1'b1; terms = 4'b0100;
    @(negedge clk);
    run = 1'b0;
    chk_all("R2 run beats firing branch", 2'd0, 1'b0, 1'b0, 1'b1);

    step(4'b0000);
    chk_all("R6 hold after run", 2'd0, 1'b0, 1'b0, 1'b1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule